// File: doc/BRIEF.md
# Programmable Root Counter with Vertical-Sync Line Counter

A 16-bit event counter for a peripheral bus. Software programs a mode word, a target value and (optionally) a preload value through a small register port. Each cycle on which the selected tick input is high, the counter advances by one. The counter can match the target or roll over past the all-ones value. Either event latches sticky status bits in the mode word and, if enabled, raises a one-cycle interrupt pulse. A regenerate bit chooses between one interrupt per arming and one interrupt per event.

Next to the counter sits a line counter driven by horizontal-sync ticks. It emits a one-cycle vertical-sync pulse once per frame. The frame length is a parameter and defaults to 263 lines.

Register addresses on `regAddr`: 0 = counter, 1 = mode, 2 = target. Read data is combinational from the address.

Top module: `root_counter`

## Requirements
- R1: After reset the counter, mode word and target all read 0, and `irq` and `vsyncPulse` are low.
- R2: Mode bit 8 picks the tick source: 0 = `sysTick`, 1 = `hsyncTick`. The counter advances by one on each cycle in which the selected tick is high, and the other tick input has no effect.
- R3: When a tick makes the counter equal to the target, mode bits 11 (target reached) and 10 (event) are both set.
- R4: When a tick advances the counter from 0xFFFF to 0, mode bits 12 (overflow) and 10 (event) are both set.
- R5: With mode bit 3 set, the tick that reaches the target returns the counter to 0. With bit 3 clear, counting continues up to the wrap.
- R6: Mode bit 4 enables the interrupt on target and bit 5 the interrupt on overflow. An interrupt is a one-cycle high pulse on `irq` in the cycle after the tick.
- R7: Mode bit 6 set: every qualifying event pulses `irq`. Bit 6 clear: only the first qualifying event after a mode write pulses `irq`.
- R8: A read of the mode register (`regRdEn` at address 1) clears bits 11 and 12 but leaves bit 10 set. An event in the same cycle as the read keeps its bit set.
- R9: A mode write stores bits 3, 4, 5, 6 and 8, clears all status bits, resets the counter to 0, re-arms the one-shot interrupt, and discards any pending preload. A tick in the same cycle is ignored.
- R10: A counter write does not change the counter at once. The next selected tick loads the written value, and that tick raises no target or overflow event.
- R11: `vsyncPulse` goes high for one cycle after every LINES_PER_FRAME (263) `hsyncTick` cycles, whatever the mode word holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (has side effects on the mode register) |
| regAddr | input | 2 | Register select: 0 counter, 1 mode, 2 target |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| sysTick | input | 1 | System tick enable |
| hsyncTick | input | 1 | Horizontal-line tick |
| irq | output | 1 | Interrupt pulse |
| vsyncPulse | output | 1 | One pulse per frame of lines |

## Verification
The hardest case to reach is a collision on one clock edge: a status read, a preload tick, a one-shot re-arm or a target hit meeting a wrap. Each needs the counter at an exact value when the strobe arrives. The random stimulus biases preloads to just below 0xFFFF and keeps targets small, including target 0. That makes target hits, wraps, reads and mode writes fall on the same cycles often. A bench model then predicts the counter, the mode word and `irq` on every cycle. Directed sequences cover the one-shot and regenerate cases, the read-clear and the 263-line frame.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_MODE   = 2'd1,
    ADDR_TARGET = 2'd2
  } regAddr_e;

  // mode word bit positions (software-visible)
  localparam int B_RST_ON_TGT = 3;
  localparam int B_IRQ_TGT    = 4;
  localparam int B_IRQ_OVF    = 5;
  localparam int B_REGEN      = 6;
  localparam int B_CLK_SEL    = 8;
  localparam int B_EVENT      = 10;
  localparam int B_HIT        = 11;
  localparam int B_OVF        = 12;

  typedef struct packed {
    logic             tick;
    logic             clear;
    logic             loadReq;
    logic [CNT_W-1:0] loadVal;
    logic             resetOnTarget;
    logic [CNT_W-1:0] target;
  } dpCmd_t;

  typedef struct packed {
    logic hitTarget;
    logic wrapped;
  } dpEvt_t;
endpackage

// File: rtl/rcnt_datapath.sv
module rcnt_datapath
  import rcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] count,
  output dpEvt_t           evt
);
  logic             pend;
  logic [CNT_W-1:0] loadHold;
  logic [CNT_W-1:0] nextVal;
  logic             countStep;

  assign nextVal   = count + 1'b1;
  assign countStep = cmd.tick & ~cmd.clear & ~pend;

  always_comb begin
    evt.wrapped   = countStep & (count == {CNT_W{1'b1}});
    evt.hitTarget = countStep & (nextVal == cmd.target);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      pend     <= 1'b0;
      loadHold <= '0;
    end else if (cmd.clear) begin
      count <= '0;
      pend  <= 1'b0;
    end else begin
      if (cmd.tick) begin
        if (pend) begin
          count <= loadHold;
          pend  <= 1'b0;
        end else if (evt.hitTarget && cmd.resetOnTarget) begin
          count <= '0;
        end else begin
          count <= nextVal;
        end
      end
      if (cmd.loadReq) begin
        pend     <= 1'b1;
        loadHold <= cmd.loadVal;
      end
    end
  end

  // R10: a pending preload is taken by the next tick
  a_r10_preload_applied: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.tick && pend && !cmd.clear) |=> (count == $past(loadHold)));

  // R4: wrap past all-ones lands on zero
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    evt.wrapped |=> (count == '0));
endmodule

// File: rtl/rcnt_ctrl.sv
module rcnt_ctrl
  import rcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              sysTick,
  input  logic              hsyncTick,
  input  logic [CNT_W-1:0]  count,
  input  dpEvt_t            evt,
  output dpCmd_t            cmd,
  output logic              irq
);
  logic cfgRstOnTgt, cfgIrqTgt, cfgIrqOvf, cfgRegen, cfgClkSel;
  logic stHit, stOvf, stEvt;
  logic armed;
  logic [CNT_W-1:0] target;
  logic modeWr, modeRd, countWr, targetWr, qualify;
  logic [CNT_W-1:0] modeWord;

  assign modeWr   = regWrEn && (regAddr == ADDR_MODE);
  assign countWr  = regWrEn && (regAddr == ADDR_COUNT);
  assign targetWr = regWrEn && (regAddr == ADDR_TARGET);
  assign modeRd   = regRdEn && (regAddr == ADDR_MODE);
  assign qualify  = (evt.hitTarget & cfgIrqTgt) | (evt.wrapped & cfgIrqOvf);

  always_comb begin
    cmd.tick          = cfgClkSel ? hsyncTick : sysTick;
    cmd.clear         = modeWr;
    cmd.loadReq       = countWr;
    cmd.loadVal       = regWrData;
    cmd.resetOnTarget = cfgRstOnTgt;
    cmd.target        = target;
  end

  always_comb begin
    modeWord               = '0;
    modeWord[B_RST_ON_TGT] = cfgRstOnTgt;
    modeWord[B_IRQ_TGT]    = cfgIrqTgt;
    modeWord[B_IRQ_OVF]    = cfgIrqOvf;
    modeWord[B_REGEN]      = cfgRegen;
    modeWord[B_CLK_SEL]    = cfgClkSel;
    modeWord[B_EVENT]      = stEvt;
    modeWord[B_HIT]        = stHit;
    modeWord[B_OVF]        = stOvf;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_COUNT:  regRdData = count;
      ADDR_MODE:   regRdData = modeWord;
      ADDR_TARGET: regRdData = target;
      default:     regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {cfgRstOnTgt, cfgIrqTgt, cfgIrqOvf, cfgRegen, cfgClkSel} <= '0;
      {stHit, stOvf, stEvt} <= '0;
      armed  <= 1'b1;
      irq    <= 1'b0;
      target <= '0;
    end else begin
      if (targetWr) target <= regWrData;
      if (modeWr) begin
        cfgRstOnTgt <= regWrData[B_RST_ON_TGT];
        cfgIrqTgt   <= regWrData[B_IRQ_TGT];
        cfgIrqOvf   <= regWrData[B_IRQ_OVF];
        cfgRegen    <= regWrData[B_REGEN];
        cfgClkSel   <= regWrData[B_CLK_SEL];
        {stHit, stOvf, stEvt} <= '0;
        armed <= 1'b1;
        irq   <= 1'b0;
      end else begin
        stHit <= (stHit & ~modeRd) | evt.hitTarget;
        stOvf <= (stOvf & ~modeRd) | evt.wrapped;
        stEvt <= stEvt | evt.hitTarget | evt.wrapped;
        irq   <= armed & qualify;
        if (armed && qualify && !cfgRegen) armed <= 1'b0;
      end
    end
  end

  // R3: a target hit latches both the reached and the event bits
  a_r3_target_flags: assert property (@(posedge clk) disable iff (!rstN)
    (evt.hitTarget && !modeWr) |=> (stHit && stEvt));

  // R8: a read with no new hit leaves the reached bit clear
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (modeRd && !evt.hitTarget && !modeWr) |=> !stHit);

  // R7: in one-shot mode no second pulse follows
  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !cfgRegen) |=> !irq);

  // R9: a mode write zeroes the counter
  a_r9_clear_count: assert property (@(posedge clk) disable iff (!rstN)
    modeWr |=> (count == '0));
endmodule

// File: rtl/rcnt_vsync.sv
module rcnt_vsync #(
  parameter int LINES_PER_FRAME = 263
) (
  input  logic clk,
  input  logic rstN,
  input  logic hsyncTick,
  output logic vsyncPulse
);
  localparam int LW = $clog2(LINES_PER_FRAME);
  localparam logic [LW-1:0] LAST = LW'(LINES_PER_FRAME - 1);

  logic [LW-1:0] lineCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt    <= '0;
      vsyncPulse <= 1'b0;
    end else begin
      vsyncPulse <= hsyncTick && (lineCnt == LAST);
      if (hsyncTick) lineCnt <= (lineCnt == LAST) ? '0 : lineCnt + 1'b1;
    end
  end

  // R11: the line index stays inside the frame and restarts at a pulse
  a_r11_line_range: assert property (@(posedge clk) disable iff (!rstN)
    vsyncPulse |-> (lineCnt == '0));
  a_r11_bound: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= LAST);
endmodule

// File: rtl/root_counter.sv
module root_counter
  import rcnt_pkg::*;
#(
  parameter int LINES_PER_FRAME = 263
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              sysTick,
  input  logic              hsyncTick,
  output logic              irq,
  output logic              vsyncPulse
);
  dpCmd_t           cmd;
  dpEvt_t           evt;
  logic [CNT_W-1:0] count;

  rcnt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sysTick(sysTick), .hsyncTick(hsyncTick), .count(count), .evt(evt),
    .cmd(cmd), .irq(irq)
  );

  rcnt_datapath u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .count(count), .evt(evt)
  );

  rcnt_vsync #(.LINES_PER_FRAME(LINES_PER_FRAME)) u_vsync (
    .clk(clk), .rstN(rstN), .hsyncTick(hsyncTick), .vsyncPulse(vsyncPulse)
  );
endmodule

// File: tb/root_counter_bench.sv
`timescale 1ns/1ps
module root_counter_bench;
  localparam int LINES = 263;

  logic clk = 1'b0;
  logic rstN;
  logic regWrEn, regRdEn, sysTick, hsyncTick;
  logic [1:0] regAddr;
  logic [15:0] regWrData, regRdData;
  logic irq, vsyncPulse;

  int checks = 0;
  int errors = 0;
  int irqSeen = 0;
  int vsSeen  = 0;

  always #4 clk = ~clk;

  root_counter #(.LINES_PER_FRAME(LINES)) u_root_counter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sysTick(sysTick), .hsyncTick(hsyncTick), .irq(irq), .vsyncPulse(vsyncPulse)
  );

  // bench model state
  logic [15:0] mCount, mLoad, mTarget;
  logic        mPend, mArmed, mHit, mOvf, mEvt, mIrq, mVs;
  logic [15:0] mCfg;
  int          mLine;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] modeOf();
    logic [15:0] m;
    m = mCfg & 16'h0178;
    m[10] = mEvt; m[11] = mHit; m[12] = mOvf;
    return m;
  endfunction

  task automatic modelReset();
    mCount = 0; mLoad = 0; mTarget = 0; mPend = 0; mArmed = 1;
    mHit = 0; mOvf = 0; mEvt = 0; mIrq = 0; mVs = 0; mCfg = 0; mLine = 0;
  endtask

  // expected effect of one clock edge, from the requirements
  task automatic modelStep(input logic wr, input logic rd, input logic [1:0] a,
                           input logic [15:0] d, input logic st, input logic ht);
    logic tick, clr, hit, wrp, qual;
    logic [15:0] nxt;
    tick = mCfg[8] ? ht : st;
    clr  = wr && a == 2'd1;
    hit = 0; wrp = 0;
    if (clr) begin
      mCount = 0; mPend = 0; mCfg = d & 16'h0178;
      mHit = 0; mOvf = 0; mEvt = 0; mArmed = 1; mIrq = 0;
    end else begin
      if (tick) begin
        if (mPend) begin
          mCount = mLoad; mPend = 0;
        end else begin
          nxt = mCount + 16'd1;
          wrp = (mCount == 16'hFFFF);
          hit = (nxt == mTarget);
          mCount = (hit && mCfg[3]) ? 16'd0 : nxt;
        end
      end
      if (wr && a == 2'd0) begin mPend = 1; mLoad = d; end
      if (rd && a == 2'd1) begin mHit = 0; mOvf = 0; end
      mHit = mHit | hit; mOvf = mOvf | wrp; mEvt = mEvt | hit | wrp;
      qual = (hit && mCfg[4]) || (wrp && mCfg[5]);
      mIrq = mArmed && qual;
      if (mIrq && !mCfg[6]) mArmed = 0;
    end
    if (wr && a == 2'd2) mTarget = d;
    mVs = ht && (mLine == LINES - 1);
    if (ht) mLine = (mLine == LINES - 1) ? 0 : mLine + 1;
  endtask

  // drive one cycle, then compare all observable state
  task automatic cyc(input logic wr, input logic rd, input logic [1:0] a,
                     input logic [15:0] d, input logic st, input logic ht);
    regWrEn = wr; regRdEn = rd; regAddr = a; regWrData = d; sysTick = st; hsyncTick = ht;
    modelStep(wr, rd, a, d, st, ht);
    @(posedge clk); #1;
    regWrEn = 0; regRdEn = 0; sysTick = 0; hsyncTick = 0;
    if (irq === 1'b1) irqSeen++;
    if (vsyncPulse === 1'b1) vsSeen++;
    check("R6/R7 irq", irq, mIrq);
    check("R11 vsync", vsyncPulse, mVs);
    regAddr = 2'd0; #1;
    check("R2/R5/R10 count", regRdData, mCount);
    regAddr = 2'd1; #1;
    check("R3/R4/R8/R9 mode", regRdData, modeOf());
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  logic [15:0] v;

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5EED1234;
    void'($urandom(seed));
    rstN = 0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    sysTick = 0; hsyncTick = 0;
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    peek(2'd0, v); check("R1 count", v, 16'h0);
    peek(2'd1, v); check("R1 mode", v, 16'h0);
    peek(2'd2, v); check("R1 target", v, 16'h0);
    check("R1 irq", irq, 1'b0);
    check("R1 vsync", vsyncPulse, 1'b0);

    // R2 tick source selection
    cyc(1, 0, 2'd2, 16'd1000, 0, 0);
    repeat (5) cyc(0, 0, 2'd0, 0, 1, 0);
    repeat (3) cyc(0, 0, 2'd0, 0, 0, 1);
    peek(2'd0, v); check("R2 sys source", v, 16'd5);
    cyc(1, 0, 2'd1, 16'h0100, 0, 0);
    repeat (3) cyc(0, 0, 2'd0, 0, 0, 1);
    repeat (4) cyc(0, 0, 2'd0, 0, 1, 0);
    peek(2'd0, v); check("R2 hsync source", v, 16'd3);

    // R3, R6 target hit with interrupt
    cyc(1, 0, 2'd2, 16'd4, 0, 0);
    cyc(1, 0, 2'd1, 16'h0010, 0, 0);
    irqSeen = 0;
    repeat (4) cyc(0, 0, 2'd0, 0, 1, 0);
    check("R6 target irq count", irqSeen, 1);
    peek(2'd1, v); check("R3 flags", v & 16'h1C00, 16'h0C00);

    // R8 read clears reached bit, keeps event bit
    cyc(0, 1, 2'd1, 0, 0, 0);
    peek(2'd1, v); check("R8 after read", v & 16'h1C00, 16'h0400);

    // R5 reset on target
    cyc(1, 0, 2'd2, 16'd3, 0, 0);
    cyc(1, 0, 2'd1, 16'h0008, 0, 0);
    repeat (3) cyc(0, 0, 2'd0, 0, 1, 0);
    peek(2'd0, v); check("R5 restart", v, 16'd0);

    // R7 one-shot versus regenerate
    cyc(1, 0, 2'd2, 16'd2, 0, 0);
    cyc(1, 0, 2'd1, 16'h0018, 0, 0);
    irqSeen = 0;
    repeat (6) cyc(0, 0, 2'd0, 0, 1, 0);
    check("R7 one-shot", irqSeen, 1);
    cyc(1, 0, 2'd1, 16'h0058, 0, 0);
    irqSeen = 0;
    repeat (6) cyc(0, 0, 2'd0, 0, 1, 0);
    check("R7 regenerate", irqSeen, 3);

    // R10 preload then R4 wrap
    cyc(1, 0, 2'd1, 16'h0020, 0, 0);
    cyc(1, 0, 2'd0, 16'hFFFF, 0, 0);
    peek(2'd0, v); check("R10 not yet loaded", v, 16'd0);
    irqSeen = 0;
    cyc(0, 0, 2'd0, 0, 1, 0);
    peek(2'd0, v); check("R10 loaded", v, 16'hFFFF);
    check("R10 no irq on load", irqSeen, 0);
    cyc(0, 0, 2'd0, 0, 1, 0);
    peek(2'd0, v); check("R4 wrapped", v, 16'd0);
    peek(2'd1, v); check("R4 flags", v & 16'h1C00, 16'h1400);
    check("R4 irq", irqSeen, 1);

    // R9 mode write clears everything, tick same cycle ignored
    cyc(1, 0, 2'd1, 16'h0000, 1, 0);
    peek(2'd1, v); check("R9 mode cleared", v, 16'h0);
    peek(2'd0, v); check("R9 count cleared", v, 16'h0);

    // R11 frame length
    begin
      int lastPulse, gap, ticks;
      lastPulse = -1; gap = 0; ticks = 0;
      for (int i = 0; i < 2 * LINES + 20; i++) begin
        vsSeen = 0;
        cyc(0, 0, 2'd0, 0, 0, 1);
        ticks++;
        if (vsSeen != 0) begin
          if (lastPulse >= 0) gap = ticks - lastPulse;
          lastPulse = ticks;
        end
      end
      check("R11 lines per frame", gap, LINES);
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [15:0] d;
      op = $urandom_range(0, 99);
      if (op < 3) begin
        d = 16'($urandom) & 16'h0178;
        if ($urandom_range(0, 1) == 0) d[8] = 1'b0;
        cyc(1, 0, 2'd1, d, $urandom_range(0, 1), $urandom_range(0, 1));
      end else if (op < 7) begin
        d = ($urandom_range(0, 1) == 0) ? 16'(16'hFFF8 + $urandom_range(0, 7))
                                        : 16'($urandom_range(0, 12));
        cyc(1, 0, 2'd0, d, $urandom_range(0, 1), $urandom_range(0, 1));
      end else if (op < 10) begin
        cyc(1, 0, 2'd2, 16'($urandom_range(0, 9)), $urandom_range(0, 1), $urandom_range(0, 1));
      end else if (op < 16) begin
        cyc(0, 1, 2'd1, 0, $urandom_range(0, 1), $urandom_range(0, 1));
      end else begin
        cyc(0, 0, 2'($urandom_range(0, 3)), 0, $urandom_range(0, 1), $urandom_range(0, 1));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule